// File: doc/BRIEF.md
# Timer and Event Counter with Pulse-Width Capture

An up-counter of parameterisable width (8 or 16 bits) that works in one of three modes. In event mode it counts edges on an external pin. In timer mode it counts a quarter-rate tick taken from the system clock. In pulse-width mode it measures one high or low interval of the external pin in quarter-rate ticks. The pin is always passed through a two-flop synchroniser first.

A preload register supplies the value that the counter takes on wrap. Software writes it, and a write made while the counter is stopped also sets the counter directly. On every wrap the block sets a sticky overflow flag. The flag drives an interrupt output through an enable bit. Each wrap also pulses a wake request, whatever the enable bit says. A read strobe stops the count for the cycle in which software samples the counter.

The pulse-width mode is one-shot. Once a measurement finishes, the block clears its own run bit and keeps the result.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter, the preload value and the control byte are zero, and both `irq` and `wake` are low.
- R2: Control byte layout: bits [7:6] select the mode (01 event, 10 timer, 11 pulse width, 00 none), bit 5 is the overflow flag, bit 4 is the run bit, bit 3 selects the edge, bit 2 enables the interrupt, and bits [1:0] read as 0. While the run bit is 0 the counter never counts.
- R3: With mode 00 the counter holds its value even when the run bit is 1.
- R4: In event mode each synchronised edge of `ext_in` adds one to the counter. The edge is rising when bit 3 is 1 and falling when bit 3 is 0.
- R5: In timer mode the counter adds one on exactly one cycle out of every four consecutive clock cycles.
- R6: An increment from the all-ones value loads the counter from the preload register and sets the overflow flag in the same cycle.
- R7: `irq` is high only while both the flag and the enable bit are set. `wake` pulses for one cycle after every overflow, whatever the enable bit says.
- R8: Writing bit 5 as 0 clears the flag. Writing it as 1 leaves the flag unchanged.
- R9: In pulse-width mode counting begins on the selected edge and stops when the pin returns to its starting level. The run bit then clears by itself and the count is held. An interval of 4N cycles yields N.
- R10: After a measurement completes, further pin activity leaves the count unchanged until software sets the run bit again.
- R11: A preload write while stopped also loads the counter. A preload write while running leaves the counter unchanged, and the new value is used at the next overflow.
- R12: While `cnt_rd` is high the counter does not increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_in | input | 1 | Asynchronous external pin |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| pre_we | input | 1 | Preload write strobe |
| pre_wdata | input | WIDTH | Preload write data |
| cnt_rd | input | 1 | Counter read strobe; stops counting for that cycle |
| cnt_q | output | WIDTH | Current counter value |
| ctl_q | output | 8 | Control byte read value |
| irq | output | 1 | Masked overflow interrupt |
| wake | output | 1 | One-cycle wake pulse on overflow |

## Verification
On every cycle the assertions check several properties:
- the counter never moves while it is stopped or being read;
- it never moves by more than one step except by a load;
- every wake pulse coincides with a set flag and a counter reloaded from the previous preload value;
- a finished measurement leaves the run bit clear.

Other behaviours can only be shown by the directed scenarios:
- exact event counts for each edge polarity;
- tick rate in timer mode;
- measured interval lengths for high and low pulses;
- the one-shot hold and re-arm;
- which preload writes reach the counter.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_in,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             pre_we,
  input  logic [WIDTH-1:0] pre_wdata,
  input  logic             cnt_rd,
  output logic [WIDTH-1:0] cnt_q,
  output logic [7:0]       ctl_q,
  output logic             irq,
  output logic             wake
);
  localparam logic [1:0] M_EVT = 2'b01;
  localparam logic [1:0] M_TMR = 2'b10;
  localparam logic [1:0] M_PW  = 2'b11;

  logic [2:0]       sync;
  logic [1:0]       div;
  logic [1:0]       mode;
  logic             flag, run, edge_sel, ie, pw_act;
  logic [WIDTH-1:0] pre_r, cnt;
  logic             rise, fall, start_e, stop_e, tick, step, inc, ovf, pw_done;

  assign rise    = sync[1] & ~sync[2];
  assign fall    = ~sync[1] & sync[2];
  assign start_e = edge_sel ? rise : fall;
  assign stop_e  = edge_sel ? fall : rise;
  assign tick    = (div == 2'd3);

  always_comb begin
    case (mode)
      M_EVT:   step = start_e;
      M_TMR:   step = tick;
      M_PW:    step = pw_act & tick;
      default: step = 1'b0;
    endcase
  end

  assign inc     = run & ~cnt_rd & step;
  assign ovf     = inc & (cnt == {WIDTH{1'b1}});
  assign pw_done = run & (mode == M_PW) & pw_act & stop_e;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= '0;
      div  <= '0;
    end else begin
      sync <= {sync[1:0], ext_in};
      div  <= div + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_r <= '0;
      cnt   <= '0;
      wake  <= 1'b0;
    end else begin
      if (pre_we) pre_r <= pre_wdata;
      if (pre_we && !run)  cnt <= pre_wdata;
      else if (ovf)        cnt <= pre_r;
      else if (inc)        cnt <= cnt + 1'b1;
      wake <= ovf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= 2'b00;
      run      <= 1'b0;
      edge_sel <= 1'b0;
      ie       <= 1'b0;
      flag     <= 1'b0;
      pw_act   <= 1'b0;
    end else begin
      if (ctl_we) begin
        mode     <= ctl_wdata[7:6];
        run      <= ctl_wdata[4];
        edge_sel <= ctl_wdata[3];
        ie       <= ctl_wdata[2];
      end else if (pw_done) begin
        run <= 1'b0;
      end
      if (ovf)                          flag <= 1'b1;
      else if (ctl_we && !ctl_wdata[5]) flag <= 1'b0;
      if (!run || mode != M_PW)         pw_act <= 1'b0;
      else if (pw_act ? stop_e : start_e) pw_act <= ~pw_act;
    end
  end

  assign cnt_q = cnt;
  assign ctl_q = {mode, flag, run, edge_sel, ie, 2'b00};
  assign irq   = flag & ie;

  // R2: a stopped counter changes only through a preload write
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[4] && !pre_we) |=> $stable(cnt_q));

  // R12: read strobe freezes the counter
  p_read_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd && !pre_we) |=> $stable(cnt_q));

  // R5: outside loads the counter only advances by one
  p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cnt_q) && !$past(pre_we) && !wake) |-> (cnt_q == WIDTH'($past(cnt_q) + 1'b1)));

  // R6: every wrap reloads from the previous preload value
  p_wrap_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (cnt_q == $past(pre_r)));

  // R7: a wake pulse comes with the flag set
  p_wake_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ctl_q[5]);

  // R9: a finished measurement leaves the run bit clear
  p_pw_autostop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pw_act) && !$past(ctl_we)) |-> !ctl_q[4]);
endmodule

// File: tb/evt_timer_tb.sv
`timescale 1ns/1ps
module evt_timer_tb_top;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_in = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic pre_we = 1'b0;
  logic [W-1:0] pre_wdata = '0;
  logic cnt_rd = 1'b0;
  logic [W-1:0] cnt_q;
  logic [7:0] ctl_q;
  logic irq, wake;

  int checks = 0;
  int fails = 0;
  int wakes = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_timer #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .pre_we(pre_we), .pre_wdata(pre_wdata),
    .cnt_rd(cnt_rd), .cnt_q(cnt_q), .ctl_q(ctl_q), .irq(irq), .wake(wake)
  );

  always @(negedge clk) if (wake) wakes++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_pre(input logic [W-1:0] v);
    @(negedge clk); pre_we = 1'b1; pre_wdata = v;
    @(negedge clk); pre_we = 1'b0;
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk); ext_in = 1'b1; step(hi);
    ext_in = 1'b0; step(lo);
  endtask

  task automatic t_reset;
    chk("R1 cnt", cnt_q, 0);
    chk("R1 ctl", ctl_q, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wake", wakes, 0);
  endtask

  task automatic t_stopped;
    int a;
    wr_ctl(8'h00); wr_pre(8'h07);
    chk("R11 stopped load", cnt_q, 7);
    wr_ctl(8'h80); a = cnt_q; step(20);
    chk("R2 no count with run 0", cnt_q, a);
    wr_ctl(8'h10); a = cnt_q; step(20);
    chk("R3 mode 00 holds", cnt_q, a);
  endtask

  task automatic t_event;
    wr_ctl(8'h00); wr_pre(8'h00);
    wr_ctl(8'h58);
    repeat (5) pulse(3, 3);
    step(4);
    chk("R4 rising edges", cnt_q, 5);
    wr_ctl(8'h50);
    repeat (3) pulse(3, 3);
    step(4);
    chk("R4 falling edges", cnt_q, 8);
  endtask

  task automatic t_timer;
    int a;
    int b;
    wr_ctl(8'h00); wr_pre(8'h00);
    wr_ctl(8'h90); step(3);
    a = cnt_q; step(40); b = cnt_q;
    chk("R5 ticks in 40 cycles", b - a, 10);
    @(negedge clk); cnt_rd = 1'b1; a = cnt_q;
    step(20); b = cnt_q;
    chk("R12 frozen during read", b, a);
    cnt_rd = 1'b0; step(8);
    chk("R12 resumes after read", cnt_q - b, 2);
  endtask

  task automatic t_overflow;
    int w0;
    wr_ctl(8'h00); wr_pre(8'hFD);
    wr_ctl(8'h54);
    w0 = wakes;
    pulse(3, 3); pulse(3, 3); step(4);
    chk("R6 reaches all-ones", cnt_q, 255);
    chk("R6 no flag yet", ctl_q[5], 0);
    pulse(3, 3); step(4);
    chk("R6 reload on wrap", cnt_q, 253);
    chk("R6 flag set", ctl_q[5], 1);
    chk("R7 irq enabled", irq, 1);
    chk("R7 one wake pulse", wakes - w0, 1);
    wr_ctl(8'h70);
    chk("R8 write 1 keeps flag", ctl_q[5], 1);
    chk("R7 irq masked", irq, 0);
    wr_ctl(8'h50);
    chk("R8 write 0 clears flag", ctl_q[5], 0);
  endtask

  task automatic t_preload_running;
    int w0;
    wr_ctl(8'h00); wr_pre(8'hFE);
    wr_ctl(8'h58);
    w0 = wakes;
    wr_pre(8'h10);
    chk("R11 running write ignored by counter", cnt_q, 254);
    pulse(3, 3); pulse(3, 3); step(4);
    chk("R11 new preload used at wrap", cnt_q, 16);
    chk("R7 wake without enable", wakes - w0, 1);
  endtask

  task automatic t_pulse;
    wr_ctl(8'h00); wr_pre(8'h00);
    wr_ctl(8'hD8); step(5);
    pulse(40, 10);
    chk("R9 high interval", cnt_q, 10);
    chk("R9 run cleared", ctl_q[4], 0);
    pulse(20, 10);
    chk("R10 later pulse ignored", cnt_q, 10);
    wr_ctl(8'hD8); step(3);
    pulse(20, 10);
    chk("R10 re-armed adds", cnt_q, 15);
    @(negedge clk); ext_in = 1'b1; step(4);
    wr_ctl(8'h00); wr_pre(8'h00);
    wr_ctl(8'hD0); step(2);
    ext_in = 1'b0; step(16);
    ext_in = 1'b1; step(8);
    chk("R9 low interval", cnt_q, 4);
    chk("R9 run cleared low", ctl_q[4], 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_stopped();
    t_event();
    t_timer();
    t_overflow();
    t_preload_running();
    t_pulse();
    finish_run();
  end
endmodule